// File: doc/BRIEF.md
# Sync-Character Hunt Receiver

This block recovers byte alignment from a serial bit stream. After it is enabled, or after the host re-arms it, the block hunts. Each accepted bit moves through an 8-bit window, and the window is compared with a programmable sync pattern. While it hunts, the block delivers nothing. When the window first equals the pattern, the block is synchronized. From then on it packs every group of eight accepted bits into a byte and presents that byte with a one-cycle valid strobe toward a receive FIFO.

The host sees a status bit that is high while the block hunts. Any change of this bit, in either direction, latches an interrupt request. The request stays set until the host clears it. A command write whose hunt bit is set forces the block back into hunting. A write whose hunt bit is clear does nothing. Clearing the enable resets the alignment, and the block hunts again when it is re-enabled.

Top module: `sync_hunt_rx`

## Requirements
- R1: After reset, hunt_stat is 1, irq is 0 and byte_vld is 0.
- R2: While hunt_stat is 1, byte_vld stays 0 in the following cycle.
- R3: Bits enter least significant first: the oldest of the last eight accepted bits lands in bit 0. On the clock edge where an accepted bit makes that window equal sync_char, hunt_stat falls to 0.
- R4: Once synchronized, the bit count restarts at zero. Every eighth accepted bit raises byte_vld for exactly one cycle after that edge. byte_data then holds those eight bits, with the first received bit in bit 0.
- R5: bit_in has no effect on any output in a cycle where bit_en is 0.
- R6: A cycle with cmd_wr=1 and cmd_hunt=1 sets hunt_stat to 1 at the next edge and restarts the bit count. A cycle with cmd_wr=1 and cmd_hunt=0 changes nothing.
- R7: A hunt command takes priority over a sync match and over byte completion in the same cycle. The block hunts afterwards and no byte is delivered.
- R8: irq is set on the same edge at which hunt_stat changes, rising or falling, whether the change came from a match, a command or the enable.
- R9: irq holds until a cycle with irq_clr=1. A status change in that same cycle keeps irq set.
- R10: While rx_en is 0, hunt_stat is 1, no byte is delivered, and the bit count and shift window are cleared to zero. After re-enable the block hunts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable |
| bit_en | input | 1 | Qualifies bit_in for this cycle |
| bit_in | input | 1 | Serial data bit |
| cmd_wr | input | 1 | Command write strobe |
| cmd_hunt | input | 1 | Hunt bit of the command write (1 re-arms the search) |
| sync_char | input | 8 | Sync pattern to hunt for |
| irq_clr | input | 1 | Clears the status interrupt request |
| byte_data | output | 8 | Last assembled byte |
| byte_vld | output | 1 | One-cycle strobe for byte_data |
| hunt_stat | output | 1 | 1 while hunting, 0 while synchronized |
| irq | output | 1 | Status-change interrupt request |

## Verification
The assertions assume that sync_char stays constant while the block is synchronized. They also assume that bit_en pulses at most once per clock, so a byte strobe is always followed by at least seven idle strobe cycles. The stimulus changes sync_char only before enabling and drives every input on the falling edge. In the directed phases it inserts gaps with noise on bit_in between accepted bits. The random phase mixes bit strobes, command writes with either hunt value, interrupt clears and short disables, and a behavioural model tracks every output on every clock.

// File: rtl/sync_hunt_pkg.sv
package sync_hunt_pkg;
  typedef enum logic {
    HS_SYNCED  = 1'b0,
    HS_HUNTING = 1'b1
  } hunt_state_e;
endpackage

// File: rtl/rx_shift_reg.sv
// Serial-in window, newest bit at the MSB so that after W shifts the
// first received bit sits at bit 0.
module rx_shift_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] win_next
);
  logic [W-1:0] win_q;

  always_comb begin
    win_next = win_q;
    if (clr) begin
      win_next = '0;
    end else if (shift_en) begin
      win_next = {bit_in, win_q[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
    end else begin
      win_q <= win_next;
    end
  end
endmodule

// File: rtl/hunt_ctrl.sv
module hunt_ctrl
  import sync_hunt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_en,
  input  logic        hunt_req,
  input  logic        shift_en,
  input  logic        match,
  output hunt_state_e state_q,
  output logic        state_change
);
  hunt_state_e state_next;

  always_comb begin
    state_next = state_q;
    if (!rx_en || hunt_req) begin
      state_next = HS_HUNTING;
    end else if (state_q == HS_HUNTING && shift_en && match) begin
      state_next = HS_SYNCED;
    end
    state_change = (state_next != state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HS_HUNTING;
    end else begin
      state_q <= state_next;
    end
  end
endmodule

// File: rtl/byte_framer.sv
module byte_framer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_en,
  input  logic         hunting,
  input  logic         hunt_req,
  input  logic         shift_en,
  input  logic [W-1:0] char_in,
  output logic [W-1:0] byte_q,
  output logic         vld_q
);
  localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [CNT_W-1:0] cnt_q, cnt_next;
  logic [W-1:0]     byte_next;
  logic             vld_next, run, done;

  always_comb begin
    run       = rx_en && !hunting && !hunt_req;
    done      = run && shift_en && (cnt_q == LAST);
    vld_next  = done;
    byte_next = byte_q;
    cnt_next  = cnt_q;
    if (!run) begin
      cnt_next = '0;
    end else if (shift_en) begin
      cnt_next = done ? '0 : cnt_q + 1'b1;
    end
    if (done) begin
      byte_next = char_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      vld_q  <= 1'b0;
      byte_q <= '0;
    end else begin
      cnt_q <= cnt_next;
      vld_q <= vld_next;
      if (done) begin
        byte_q <= byte_next;
      end
    end
  end
endmodule

// File: rtl/status_irq.sv
module status_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic status_change,
  input  logic irq_clr,
  output logic irq_q
);
  logic irq_next;

  always_comb begin
    irq_next = status_change | (irq_q & ~irq_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_next;
    end
  end
endmodule

// File: rtl/sync_hunt_rx.sv
module sync_hunt_rx
  import sync_hunt_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              bit_en,
  input  logic              bit_in,
  input  logic              cmd_wr,
  input  logic              cmd_hunt,
  input  logic [CHAR_W-1:0] sync_char,
  input  logic              irq_clr,
  output logic [CHAR_W-1:0] byte_data,
  output logic              byte_vld,
  output logic              hunt_stat,
  output logic              irq
);
  logic              shift_en, hunt_req, match, state_change;
  logic [CHAR_W-1:0] win_next;
  hunt_state_e       state_q;

  assign shift_en  = rx_en & bit_en;
  assign hunt_req  = cmd_wr & cmd_hunt;
  assign match     = (win_next == sync_char);
  assign hunt_stat = (state_q == HS_HUNTING);

  rx_shift_reg #(.W(CHAR_W)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (~rx_en),
    .shift_en (shift_en),
    .bit_in   (bit_in),
    .win_next (win_next)
  );

  hunt_ctrl u_hunt (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_en        (rx_en),
    .hunt_req     (hunt_req),
    .shift_en     (shift_en),
    .match        (match),
    .state_q      (state_q),
    .state_change (state_change)
  );

  byte_framer #(.W(CHAR_W)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_en    (rx_en),
    .hunting  (hunt_stat),
    .hunt_req (hunt_req),
    .shift_en (shift_en),
    .char_in  (win_next),
    .byte_q   (byte_data),
    .vld_q    (byte_vld)
  );

  status_irq u_irq (
    .clk           (clk),
    .rst_n         (rst_n),
    .status_change (state_change),
    .irq_clr       (irq_clr),
    .irq_q         (irq)
  );
endmodule

// File: rtl/sync_hunt_rx_chk.sv
module sync_hunt_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_en,
  input logic cmd_wr,
  input logic cmd_hunt,
  input logic irq_clr,
  input logic byte_vld,
  input logic hunt_stat,
  input logic irq
);
  // R2
  no_byte_in_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hunt_stat |=> !byte_vld);

  // R4
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld);

  // R6
  cmd_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_hunt) |=> hunt_stat);

  // R8
  irq_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hunt_stat) |-> irq);

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  // R10
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (hunt_stat && !byte_vld));
endmodule

bind sync_hunt_rx sync_hunt_rx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_en     (rx_en),
  .cmd_wr    (cmd_wr),
  .cmd_hunt  (cmd_hunt),
  .irq_clr   (irq_clr),
  .byte_vld  (byte_vld),
  .hunt_stat (hunt_stat),
  .irq       (irq)
);

// File: tb/sync_hunt_rx_test.sv
module sync_hunt_rx_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n, rx_en, bit_en, bit_in, cmd_wr, cmd_hunt, irq_clr;
  logic [7:0] sync_char, byte_data;
  logic       byte_vld, hunt_stat, irq;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int nbytes = 0;
  logic [7:0] last_byte = 8'h00;

  // behavioural reference state
  bit       m_hunt, m_irq, m_vld;
  bit [7:0] m_sr, m_data;
  int       m_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_hunt_rx uut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .bit_en(bit_en), .bit_in(bit_in),
    .cmd_wr(cmd_wr), .cmd_hunt(cmd_hunt), .sync_char(sync_char), .irq_clr(irq_clr),
    .byte_data(byte_data), .byte_vld(byte_vld), .hunt_stat(hunt_stat), .irq(irq)
  );

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model, R3 R4 R6 R7 R8 R9 R10
  always @(posedge clk) begin
    bit nh; bit [7:0] nsr; int ncnt; bit nvld;
    if (!rst_n) begin
      m_hunt <= 1; m_irq <= 0; m_vld <= 0; m_sr <= 0; m_cnt <= 0;
    end else begin
      nh = m_hunt; nsr = m_sr; ncnt = m_cnt; nvld = 0;
      if (!rx_en) begin
        nh = 1; nsr = 0; ncnt = 0;
      end else begin
        if (bit_en) nsr = {bit_in, m_sr[7:1]};
        if (cmd_wr && cmd_hunt) begin
          nh = 1; ncnt = 0;
        end else if (m_hunt) begin
          ncnt = 0;
          if (bit_en && nsr == sync_char) nh = 0;
        end else if (bit_en) begin
          if (m_cnt == 7) begin
            nvld = 1; ncnt = 0; m_data <= nsr;
          end else ncnt = m_cnt + 1;
        end
      end
      m_irq <= (nh != m_hunt) ? 1'b1 : (m_irq && !irq_clr);
      m_hunt <= nh; m_sr <= nsr; m_cnt <= ncnt; m_vld <= nvld;
    end
  end

  // per-cycle comparison and byte capture
  always @(negedge clk) begin
    if (rst_n) begin
      check(hunt_stat === m_hunt, "R3 hunt_stat vs model", int'(hunt_stat), int'(m_hunt));
      check(irq === m_irq, "R8 irq vs model", int'(irq), int'(m_irq));
      check(byte_vld === m_vld, "R4 byte_vld vs model", int'(byte_vld), int'(m_vld));
      if (m_vld)
        check(byte_data === m_data, "R4 byte_data vs model", int'(byte_data), int'(m_data));
      if (byte_vld === 1'b1) begin
        nbytes++;
        last_byte = byte_data;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      checks++; errors++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  task automatic send_bit(input logic b);
    bit_en = 1; bit_in = b;
    @(negedge clk);
    bit_en = 0; bit_in = ~b;   // noise while not qualified, R5
  endtask

  task automatic send_byte(input logic [7:0] v, input int gap);
    for (int i = 0; i < 8; i++) begin
      send_bit(v[i]);
      for (int g = 0; g < gap; g++) begin
        bit_in = 1'($urandom);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    int n0;
    rst_n = 0; rx_en = 0; bit_en = 0; bit_in = 0; cmd_wr = 0; cmd_hunt = 0;
    irq_clr = 0; sync_char = 8'h96;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(hunt_stat === 1'b1, "R1 hunt_stat after reset", int'(hunt_stat), 1);
    check(irq === 1'b0, "R1 irq after reset", int'(irq), 0);
    check(byte_vld === 1'b0, "R1 byte_vld after reset", int'(byte_vld), 0);
    rst_n = 1;
    @(negedge clk);
    rx_en = 1;
    @(negedge clk);

    // R2 noise while hunting delivers nothing
    send_byte(8'h00, 1);
    send_byte(8'hFF, 0);
    check(nbytes == 0, "R2 no bytes while hunting", nbytes, 0);
    check(hunt_stat === 1'b1, "R2 still hunting", int'(hunt_stat), 1);

    // R3 sync found, R8 irq on falling status
    send_byte(8'h96, 0);
    check(hunt_stat === 1'b0, "R3 synchronized after pattern", int'(hunt_stat), 0);
    check(irq === 1'b1, "R8 irq after sync", int'(irq), 1);
    irq_clr = 1; @(negedge clk); irq_clr = 0;
    check(irq === 1'b0, "R9 irq cleared", int'(irq), 0);

    // R4 R5 byte with gaps and noise on bit_in
    send_byte(8'hA5, 2);
    repeat (2) @(negedge clk);
    check(nbytes == 1 && last_byte == 8'hA5, "R4 R5 first byte", int'(last_byte), 8'hA5);
    send_byte(8'h3C, 0);
    repeat (2) @(negedge clk);
    check(last_byte == 8'h3C, "R4 back-to-back byte", int'(last_byte), 8'h3C);

    // R6 write with hunt bit clear: no effect
    cmd_wr = 1; cmd_hunt = 0; @(negedge clk); cmd_wr = 0;
    check(hunt_stat === 1'b0, "R6 zero command ignored", int'(hunt_stat), 0);
    send_byte(8'h81, 0);
    repeat (2) @(negedge clk);
    check(last_byte == 8'h81, "R6 alignment kept", int'(last_byte), 8'h81);
    // R6 R8 hunt command
    cmd_wr = 1; cmd_hunt = 1; @(negedge clk); cmd_wr = 0; cmd_hunt = 0;
    check(hunt_stat === 1'b1, "R6 command re-arms hunt", int'(hunt_stat), 1);
    check(irq === 1'b1, "R8 irq on command-caused rise", int'(irq), 1);

    // R9 status change during clear keeps irq
    send_byte(8'h96 & 8'h7F, 0);  // partial noise
    irq_clr = 1;
    send_byte(8'h96, 0);
    irq_clr = 0;
    check(hunt_stat === 1'b0 && irq === 1'b1, "R9 set wins over clear", int'(irq), 1);
    irq_clr = 1; @(negedge clk); irq_clr = 0;

    // R7 hunt command on the eighth bit suppresses the byte
    n0 = nbytes;
    for (int i = 0; i < 7; i++) send_bit(1'b1);
    cmd_wr = 1; cmd_hunt = 1;
    send_bit(1'b0);
    cmd_wr = 0; cmd_hunt = 0;
    repeat (2) @(negedge clk);
    check(nbytes == n0, "R7 no byte under command", nbytes, n0);
    check(hunt_stat === 1'b1, "R7 hunting after command", int'(hunt_stat), 1);

    // R10 disable mid-byte, re-enable
    send_byte(8'h96, 0);
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    rx_en = 0;
    n0 = nbytes;
    for (int i = 0; i < 9; i++) send_bit(1'b0);
    check(hunt_stat === 1'b1 && nbytes == n0, "R10 disabled hunts, no bytes", int'(hunt_stat), 1);
    rx_en = 1; @(negedge clk);
    check(hunt_stat === 1'b1, "R10 hunting after re-enable", int'(hunt_stat), 1);
    send_byte(8'h96, 1);
    send_byte(8'h5A, 0);
    repeat (2) @(negedge clk);
    check(last_byte == 8'h5A, "R10 alignment restarts", int'(last_byte), 8'h5A);

    // mixed random traffic against the model
    for (int k = 0; k < 3000; k++) begin
      if (($urandom % 97) == 0) begin
        send_byte(8'h96, 0);
      end else begin
        bit_en   = 1'($urandom);
        bit_in   = 1'($urandom);
        cmd_wr   = (($urandom % 40) == 0);
        cmd_hunt = 1'($urandom);
        irq_clr  = (($urandom % 8) == 0);
        if (($urandom % 200) == 0) rx_en = ~rx_en;
        else if (!rx_en && ($urandom % 4) == 0) rx_en = 1;
        @(negedge clk);
        bit_en = 0; cmd_wr = 0; cmd_hunt = 0; irq_clr = 0;
      end
    end

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule